// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Controller

This block supervises software through one 8-bit control register. A timeout counter runs whenever the interrupt enable or the reset enable is set. Its period is picked by a two-bit select field. When the period elapses, an interrupt flag is raised. The rising edge of that flag opens a fixed 512-cycle reset window. If software neither restarts the watchdog nor clears the flag before the window closes, a one-cycle reset request is produced, but only when the reset enable is set.

There are two reset inputs. The power-on reset loads a fixed register value. The other reset keeps the reset enable, the watchdog-reset flag, the interrupt enable and the spare bit, and clears everything else. The reset enable may be written only once per power-on. Software reaches the register through a write strobe with data and a combinational read port.

Register layout: bit 7 spare (read/write), bit 6 interrupt enable, bits 5:4 timeout select, bit 3 interrupt flag, bit 2 watchdog-reset flag, bit 1 reset enable, bit 0 restart (write-only).

Top module: `wdt_ctl`

## Requirements
- R1: After power-on reset the register reads 0xB2, and irq and wdt_rst are low.
- R2: The other reset (rst_n low) keeps bits 7, 6, 2 and 1 and clears bits 5, 4, 3 and 0. After a watchdog reset with bit 6 = 1 and bit 1 = 1, the register reads 0x46.
- R3: The first write after power-on loads bit 1, the reset enable. Writes after that leave it unchanged. This lock survives the other reset and is released only by power-on reset.
- R4: Timeout select value s (bits 5:4) sets a timeout of 2^(9+3s) cycles from a restart. A write that changes the field restarts the counter.
- R5: A timeout sets the interrupt flag (bit 3). irq is high while bit 3 and bit 6 are both 1.
- R6: Software can only clear the interrupt flag, by writing 0 to bit 3. Writing 1 to bit 3 leaves it unchanged.
- R7: The edge that raises the flag opens a window. With the reset enable set, wdt_rst pulses high for exactly one cycle, 512 cycles after that edge, and bit 2 becomes 1.
- R8: Writing 1 to bit 0 clears the counter and closes any open window. Bit 0 always reads 0. When a restart and a timeout fall on the same cycle, the restart wins and the next timeout comes a full period later.
- R9: Clearing the flag while the window is open cancels the pending reset.
- R10: Bit 2 is cleared by power-on reset or by writing 0 to it. Writing 1 to it has no effect. With the reset enable at 0, a closing window produces no wdt_rst and bit 2 stays 0.
- R11: While bits 6 and 1 are both 0, the counter holds its value and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Other (system) reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Watchdog interrupt request |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest case to reach from the ports is a restart write that lands on exactly the same edge as a timeout. The stimulus restarts the counter and then counts cycles, so that the second restart write lands on the 512th edge. A correct design shows no flag at that point and raises the flag a full period later. The reset path is driven to completion, and the bench then applies the other reset to show which bits survive. A separate power-on with the reset enable locked to 0 shows that the counter is frozen, and that a closing window produces no reset.

// File: rtl/wdt_ctl.sv
module wdt_ctl #(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 3,
  parameter int WIN_CYC   = 512
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       wdt_rst
);
  localparam int CW = BASE_LOG2 + 3 * STEP_LOG2;
  localparam int WW = $clog2(WIN_CYC);

  logic          spare, ie, flag, rflag, ren, lock, wact, rst_q;
  logic [1:0]    sel;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic [CW:0]   lim, lastv;

  always_comb begin
    lim   = (CW+1)'(1) << (BASE_LOG2 + STEP_LOG2 * int'(sel));
    lastv = lim - (CW+1)'(1);
  end

  wire run     = ie | ren;
  wire restart = wr_en & wr_data[0];
  wire sel_chg = wr_en & (wr_data[5:4] != sel);
  wire tmo     = run & ({1'b0, cnt} == lastv) & ~restart & ~sel_chg;
  wire fclr    = wr_en & ~wr_data[3] & flag;
  wire cancel  = restart | fclr;
  wire start   = tmo & ~flag;
  wire expire  = run & wact & (wcnt == WW'(WIN_CYC - 1)) & ~cancel;
  wire fire    = expire & ren;

  assign rd_data = {spare, ie, sel, flag, rflag, ren, 1'b0};
  assign irq     = flag & ie;
  assign wdt_rst = rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      spare <= 1'b1;
      ie    <= 1'b0;
      rflag <= 1'b0;
      ren   <= 1'b1;
      lock  <= 1'b0;
    end else if (rst_n) begin
      if (wr_en) begin
        spare <= wr_data[7];
        ie    <= wr_data[6];
        lock  <= 1'b1;
        if (!lock) ren <= wr_data[1];
      end
      rflag <= (rflag & ~(wr_en & ~wr_data[2])) | fire;
    end
  end

  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n) begin
      sel   <= 2'b11;
      flag  <= 1'b0;
      cnt   <= '0;
      wact  <= 1'b0;
      wcnt  <= '0;
      rst_q <= 1'b0;
    end else if (!rst_n) begin
      sel   <= 2'b00;
      flag  <= 1'b0;
      cnt   <= '0;
      wact  <= 1'b0;
      wcnt  <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= fire;
      if (wr_en) sel <= wr_data[5:4];
      flag <= tmo | (flag & ~fclr);

      if (restart | sel_chg) cnt <= '0;
      else if (run)          cnt <= tmo ? '0 : cnt + 1'b1;

      if (cancel) begin
        wact <= 1'b0;
      end else if (run) begin
        if (start) begin
          wact <= 1'b1;
          wcnt <= '0;
        end else if (wact) begin
          if (expire) wact <= 1'b0;
          else        wcnt <= wcnt + 1'b1;
        end
      end
    end
  end
endmodule

module wdt_ctl_chk #(parameter int CW = 18) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic [7:0]    rd_data,
  input logic          irq,
  input logic          wdt_rst,
  input logic          lock,
  input logic          ren,
  input logic [CW-1:0] cnt
);
  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wdt_rst |=> !wdt_rst);
  assert_rst_flag_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wdt_rst |-> rd_data[2]);
  assert_no_rst_wo_en_R10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wdt_rst |-> ren);
  assert_en_locked_R3: assert property (@(posedge clk) disable iff (!por_n)
    lock |=> $stable(ren));
  assert_gated_hold_R11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (!rd_data[6] && !rd_data[1] && !wr_en) |=> $stable(cnt));
  assert_restart_clr_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_en && wr_data[0]) |=> (cnt == '0));
  assert_irq_flag_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    irq |-> (rd_data[3] && rd_data[6]));
  assert_bit0_zero_R8: assert property (@(posedge clk) disable iff (!por_n)
    !rd_data[0]);
endmodule

bind wdt_ctl wdt_ctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq(irq), .wdt_rst(wdt_rst), .lock(lock), .ren(ren), .cnt(cnt)
);

// File: tb/sim_wdt_ctl.sv
`timescale 1ns/1ps
module sim_wdt_ctl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, wdt_rst;
  int nchk = 0;
  int nfail = 0;

  wdt_ctl u0 (.clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en),
              .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .wdt_rst(wdt_rst));

  always #2 clk = ~clk;

  localparam logic [15:0] VEC [5] = '{16'h4E42, 16'hC1C2, 16'h9C92, 16'h3F32, 16'h0002};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic watch_rst(input int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wdt_rst) hits++;
    end
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    step(2);
    por_n = 1'b1;
    step(1);
  endtask

  initial begin
    #(4 * 190000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int hits;
    step(3);
    por_n = 1'b1;
    step(1);
    chk("R1 por value", rd_data, 8'hB2);
    chk("R1 irq low", irq, 0);
    chk("R1 rst low", wdt_rst, 0);

    // R3 R6 R8 R10 register write table
    for (int i = 0; i < 5; i++) begin
      wr(VEC[i][15:8]);
      chk("R3/R6/R8/R10 table", rd_data, VEC[i][7:0]);
    end

    // R4 R5: timeout at 512 after restart
    wr(8'h43);
    step(511);
    chk("R4 no early timeout", rd_data[3], 0);
    step(1);
    chk("R5 flag set", rd_data[3], 1);
    chk("R5 irq", irq, 1);

    // R7 reset window
    step(511);
    chk("R7 no early reset", wdt_rst, 0);
    step(1);
    chk("R7 reset pulse", wdt_rst, 1);
    chk("R7 reset flag", rd_data[2], 1);
    step(1);
    chk("R7 single cycle", wdt_rst, 0);

    // R2 other reset
    @(negedge clk);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R2 preserved bits", rd_data, 8'h46);
    chk("R2 irq cleared", irq, 0);
    wr(8'h40);
    chk("R3 lock survives, R10 clear", rd_data, 8'h42);

    // R8 restart on the timeout edge
    wr(8'h43);
    step(510);
    wr(8'h43);
    chk("R8 restart wins", rd_data[3], 0);
    step(511);
    chk("R8 full period", rd_data[3], 0);
    step(1);
    chk("R8 timeout after reload", rd_data[3], 1);

    // R8 restart inside window
    step(300);
    wr(8'h4B);
    watch_rst(600, hits);
    chk("R8 restart cancels reset", hits, 0);
    chk("R6 flag kept", irq, 1);

    // R9 flag clear cancels
    wr(8'h43);
    step(511);
    step(1);
    chk("R9 flag up", rd_data[3], 1);
    step(100);
    wr(8'h42);
    chk("R9 flag cleared", rd_data[3], 0);
    watch_rst(487, hits);
    chk("R9 no reset", hits, 0);

    // R11 R10 with reset enable locked to 0
    do_por();
    chk("R1 por value again", rd_data, 8'hB2);
    wr(8'h00);
    chk("R3 enable locked 0", rd_data, 8'h00);
    step(600);
    chk("R11 counter stopped", rd_data[3], 0);
    wr(8'h02);
    chk("R3 second write ignored", rd_data, 8'h00);
    wr(8'h40);
    step(511);
    chk("R11 resume early", rd_data[3], 0);
    step(1);
    chk("R11 resume timeout", rd_data[3], 1);
    watch_rst(600, hits);
    chk("R10 no reset when disabled", hits, 0);
    chk("R10 flag stays 0", rd_data[2], 0);

    // R4 select change restarts, longer period
    wr(8'h43);
    step(400);
    wr(8'h53);
    chk("R4 readback", rd_data, 8'h50);
    step(4095);
    chk("R4 sel01 no early", rd_data[3], 0);
    step(1);
    chk("R4 sel01 timeout", rd_data[3], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule